// File: doc/BRIEF.md
# Cascadable 8-bit Timer Clock Selector

This block is one channel of an 8-bit timer. A 3-bit select input decides which event advances the channel's up-counter. The counter can be stopped. It can step on the falling edge of one of three divided versions of the system clock. It can step on an event from a companion channel. It can also step on the rising edge, the falling edge or both edges of an external clock pin. Each chosen event becomes a single-cycle count-enable pulse, and the counter advances by one on the clock edge that follows.

Two instances form a pair. The even member (parameter `IS_ODD` = 0) uses the odd member's overflow pulse as its cascade event. The odd member (`IS_ODD` = 1) uses the even member's compare-match-A pulse. Each channel drives its own wrap pulse, and a compare-match-A pulse against an 8-bit constant, so that its partner can chain on it. The external pin is asynchronous and passes through a two-flop synchronizer before its edges are detected.

Top module: `tmr_clksel_chan`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, the count reads 0 and the count-enable, wrap and match pulses are all low.
- R2: Select code 3'b000 produces no count-enable pulses, and the count holds even while the external pin toggles.
- R3: Select code 3'b001 advances the count on each falling edge of the system clock divided by 8, which is exactly 8 steps in any window of 64 cycles.
- R4: Select code 3'b010 advances the count once per 64 cycles, which is exactly 8 steps in any window of 512 cycles.
- R5: Select code 3'b011 advances the count once per 8192 cycles, which is exactly 2 steps in any window of 16384 cycles.
- R6: On the even channel, select code 3'b100 advances the count once for each wrap pulse on the partner-wrap input.
- R7: On the odd channel, select code 3'b100 advances the count once for each pulse on the partner-match input.
- R8: Select code 3'b101 advances the count once for each low-to-high transition of the external pin, after a two-flop synchronizer.
- R9: Select code 3'b110 advances the count once for each high-to-low transition of the external pin.
- R10: Select code 3'b111 advances the count once for each transition of the external pin in either direction, even when the pin toggles on consecutive cycles.
- R11: A step from 8'hFF goes to 8'h00. The wrap output is high for exactly the one cycle in which the count first reads 8'h00.
- R12: The match output is high for exactly one cycle, the cycle in which the count first reads the compare constant after a step. With a constant of 8'h00, it rises in the same cycle as the wrap pulse.
- R13: Every count-enable pulse is followed by a count one higher on the next cycle. With no pulse, the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count source select code |
| ext_clk | input | 1 | Asynchronous external clock pin |
| partner_ovf | input | 1 | Wrap pulse from the odd partner (used by the even channel) |
| partner_cma | input | 1 | Match pulse from the even partner (used by the odd channel) |
| cmp_a | input | 8 | Compare constant for the match pulse |
| cnt_en | output | 1 | Single-cycle count-enable pulse |
| cnt_val | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle pulse on a wrap from 8'hFF to 8'h00 |
| cma_pulse | output | 1 | One-cycle pulse when a step lands on the compare constant |

## Verification
The wrap pulse and the match pulse can fire in the same cycle. This happens when the compare constant is 8'h00, because the step that wraps the counter also lands it on the constant. The bench loads 8'h00 into the even channel's compare constant, runs that channel from the divide-by-8 tap, and polls until the wrap pulse appears. In that same sample it requires the match pulse to be high and the count to read 0. On the following sample it requires both pulses to be low again. A second case uses a non-zero constant and requires a match pulse with no wrap pulse.

// File: rtl/tmr_clksel_pkg.sv
package tmr_clksel_pkg;

  typedef enum logic [2:0] {
    SRC_OFF      = 3'b000,
    SRC_DIV_A    = 3'b001,
    SRC_DIV_B    = 3'b010,
    SRC_DIV_C    = 3'b011,
    SRC_CASCADE  = 3'b100,
    SRC_EXT_RISE = 3'b101,
    SRC_EXT_FALL = 3'b110,
    SRC_EXT_BOTH = 3'b111
  } src_sel_e;

  localparam int unsigned NUM_TAPS = 3;
  localparam int unsigned TAP_FW   = 8;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PRE_W    = 13,
  parameter int unsigned NUM_TAPS = 3,
  parameter int unsigned TAP_FW   = 8,
  parameter logic [NUM_TAPS*TAP_FW-1:0] TAP_BITS = {8'd12, 8'd5, 8'd2}
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap_fall
);

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [NUM_TAPS-1:0] tap_now, tap_q;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int unsigned BITPOS = int'(TAP_BITS[g*TAP_FW +: TAP_FW]);
    assign tap_now[g]  = pre_q[BITPOS];
    assign tap_fall[g] = tap_q[g] & ~tap_now[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tap_q <= '0;
    end else begin
      pre_q <= pre_d;
      tap_q <= tap_now;
    end
  end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/tmr_src_mux.sv
module tmr_src_mux
  import tmr_clksel_pkg::*;
#(
  parameter bit          IS_ODD   = 1'b0,
  parameter int unsigned NUM_TAPS = 3
) (
  input  logic [2:0]          sel,
  input  logic [NUM_TAPS-1:0] tap_fall,
  input  logic                partner_ovf,
  input  logic                partner_cma,
  input  logic                ext_rise,
  input  logic                ext_fall,
  output logic                en
);

  logic casc_evt;
  assign casc_evt = IS_ODD ? partner_cma : partner_ovf;

  always_comb begin
    unique case (src_sel_e'(sel))
      SRC_OFF:      en = 1'b0;
      SRC_DIV_A:    en = tap_fall[0];
      SRC_DIV_B:    en = tap_fall[1];
      SRC_DIV_C:    en = tap_fall[2];
      SRC_CASCADE:  en = casc_evt;
      SRC_EXT_RISE: en = ext_rise;
      SRC_EXT_FALL: en = ext_fall;
      SRC_EXT_BOTH: en = ext_rise | ext_fall;
      default:      en = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             cma
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ovf_q, ovf_d, cma_q, cma_d;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = en ? cnt_inc : cnt_q;
    ovf_d   = en && (cnt_q == {CNT_W{1'b1}});
    cma_d   = en && (cnt_inc == cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      cma_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      cma_q <= cma_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
  assign cma = cma_q;

endmodule

// File: rtl/tmr_clksel_chan.sv
module tmr_clksel_chan
  import tmr_clksel_pkg::*;
#(
  parameter bit          IS_ODD      = 1'b0,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 13,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_TAPS*TAP_FW-1:0] TAP_BITS = {8'd12, 8'd5, 8'd2}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             ext_clk,
  input  logic             partner_ovf,
  input  logic             partner_cma,
  input  logic [CNT_W-1:0] cmp_a,
  output logic             cnt_en,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_pulse,
  output logic             cma_pulse
);

  logic [NUM_TAPS-1:0] tap_fall;
  logic                ext_rise, ext_fall;

  tmr_prescale #(
    .PRE_W    (PRE_W),
    .NUM_TAPS (NUM_TAPS),
    .TAP_FW   (TAP_FW),
    .TAP_BITS (TAP_BITS)
  ) u_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap_fall (tap_fall)
  );

  tmr_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_edge_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_clk),
    .rise     (ext_rise),
    .fall     (ext_fall)
  );

  tmr_src_mux #(
    .IS_ODD   (IS_ODD),
    .NUM_TAPS (NUM_TAPS)
  ) u_src_mux (
    .sel         (clk_sel),
    .tap_fall    (tap_fall),
    .partner_ovf (partner_ovf),
    .partner_cma (partner_cma),
    .ext_rise    (ext_rise),
    .ext_fall    (ext_fall),
    .en          (cnt_en)
  );

  tmr_up_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .cmp   (cmp_a),
    .cnt   (cnt_val),
    .ovf   (ovf_pulse),
    .cma   (cma_pulse)
  );

endmodule

// File: rtl/tmr_clksel_chan_chk.sv
module tmr_clksel_chan_chk #(
  parameter bit          IS_ODD = 1'b0,
  parameter int unsigned CNT_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       clk_sel,
  input logic             partner_ovf,
  input logic             partner_cma,
  input logic [CNT_W-1:0] cmp_a,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_pulse,
  input logic             cma_pulse
);

  // R2: a stopped source never enables and the count stays put
  p_off_no_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b000) |-> !cnt_en);

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b000) |=> $stable(cnt_val));

  // R13: one step per enable, none otherwise
  p_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> (cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1))));

  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_val));

  // R11: wrap pulse only on the FF -> 00 step, one cycle wide
  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_pulse) |-> (cnt_val == '0) && ($past(cnt_val) == {CNT_W{1'b1}}));

  p_wrap_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  // R12: match pulse lands with the count on the constant
  p_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cma_pulse |-> (cnt_val == $past(cmp_a)));

  generate
    if (IS_ODD) begin : g_odd
      // R7: partner match drives a step when cascading
      p_casc_cma_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b100 && partner_cma) |-> cnt_en);
    end else begin : g_even
      // R6: partner wrap drives a step when cascading
      p_casc_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'b100 && partner_ovf) |-> cnt_en);
    end
  endgenerate

endmodule

bind tmr_clksel_chan tmr_clksel_chan_chk #(
  .IS_ODD (IS_ODD),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_sel     (clk_sel),
  .partner_ovf (partner_ovf),
  .partner_cma (partner_cma),
  .cmp_a       (cmp_a),
  .cnt_en      (cnt_en),
  .cnt_val     (cnt_val),
  .ovf_pulse   (ovf_pulse),
  .cma_pulse   (cma_pulse)
);

// File: tb/tmr_clksel_chan_bench.sv
`timescale 1ns/1ps
module tmr_clksel_chan_bench;

  typedef struct packed {
    logic        tgt;   // 0 = even channel measured, 1 = odd
    logic [2:0]  tsel;  // select code for the measured channel
    logic [2:0]  osel;  // select code for the other channel
    logic [15:0] win;   // window length in cycles
    logic [3:0]  exth;  // external toggle spacing, 0 = no toggling
    logic [7:0]  expd;  // expected count increase
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 3'd0, 3'd0, 16'd99,    4'd3, 8'd0},  // R2 stopped, pin toggles
    '{1'b0, 3'd1, 3'd0, 16'd64,    4'd0, 8'd8},  // R3 even /8
    '{1'b1, 3'd1, 3'd0, 16'd128,   4'd0, 8'd16}, // R3 odd /8
    '{1'b0, 3'd2, 3'd0, 16'd512,   4'd0, 8'd8},  // R4 /64
    '{1'b0, 3'd3, 3'd0, 16'd16384, 4'd0, 8'd2},  // R5 /8192
    '{1'b0, 3'd4, 3'd1, 16'd4096,  4'd0, 8'd2},  // R6 even on odd wrap
    '{1'b1, 3'd4, 3'd1, 16'd4096,  4'd0, 8'd2},  // R7 odd on even match
    '{1'b0, 3'd5, 3'd0, 16'd21,    4'd3, 8'd4},  // R8 rising
    '{1'b1, 3'd6, 3'd0, 16'd21,    4'd3, 8'd3},  // R9 falling
    '{1'b0, 3'd7, 3'd0, 16'd21,    4'd3, 8'd7},  // R10 both
    '{1'b1, 3'd7, 3'd0, 16'd10,    4'd1, 8'd10}  // R10 back-to-back toggles
  };

  logic       clk, rst_n, ext;
  logic [2:0] sel_e, sel_o;
  logic [7:0] cmp_e, cmp_o;
  logic       en_e, ovf_e, cma_e, en_o, ovf_o, cma_o;
  logic [7:0] cnt_e, cnt_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  tmr_clksel_chan #(.IS_ODD(1'b0)) u_tmr_clksel_chan (
    .clk(clk), .rst_n(rst_n), .clk_sel(sel_e), .ext_clk(ext),
    .partner_ovf(ovf_o), .partner_cma(1'b0), .cmp_a(cmp_e),
    .cnt_en(en_e), .cnt_val(cnt_e), .ovf_pulse(ovf_e), .cma_pulse(cma_e));

  tmr_clksel_chan #(.IS_ODD(1'b1)) u_tmr_clksel_chan_odd (
    .clk(clk), .rst_n(rst_n), .clk_sel(sel_o), .ext_clk(ext),
    .partner_ovf(1'b0), .partner_cma(cma_e), .cmp_a(cmp_o),
    .cnt_en(en_o), .cnt_val(cnt_o), .ovf_pulse(ovf_o), .cma_pulse(cma_o));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6/R7 cascade";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic set_sel(input logic tgt, input logic [2:0] t, input logic [2:0] o);
    if (tgt) begin sel_o = t; sel_e = o; end
    else     begin sel_e = t; sel_o = o; end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    logic [7:0] s, e;
    bit seen;
    rst_n = 1'b0; ext = 1'b0; sel_e = 3'd0; sel_o = 3'd0;
    cmp_e = 8'd5; cmp_o = 8'h80;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(cnt_e == 0 && !en_e && !ovf_e && !cma_e, "R1 even in reset", int'(cnt_e), 0);
    chk(cnt_o == 0 && !en_o && !ovf_o && !cma_o, "R1 odd in reset", int'(cnt_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt_e == 0 && !ovf_e && !cma_e, "R1 after release", int'(cnt_e), 0);

    for (int v = 0; v < NVEC; v++) begin
      ext = 1'b0; sel_e = 3'd0; sel_o = 3'd0;
      repeat (6) @(negedge clk);
      set_sel(TBL[v].tgt, TBL[v].tsel, TBL[v].osel);
      s = TBL[v].tgt ? cnt_o : cnt_e;
      for (int i = 0; i < int'(TBL[v].win); i++) begin
        @(negedge clk);
        if (TBL[v].exth != 0 && (i % int'(TBL[v].exth)) == int'(TBL[v].exth) - 1)
          ext = ~ext;
      end
      set_sel(TBL[v].tgt, TBL[v].tsel, 3'd0);
      if (TBL[v].osel != 0 || TBL[v].exth != 0) repeat (6) @(negedge clk);
      e = TBL[v].tgt ? cnt_o : cnt_e;
      set_sel(TBL[v].tgt, 3'd0, 3'd0);
      chk(8'(e - s) == TBL[v].expd, req_of(TBL[v].tsel), int'(8'(e - s)), int'(TBL[v].expd));
    end

    // R13: one external edge gives one enable and one step
    ext = 1'b0; sel_e = 3'd5;
    repeat (6) @(negedge clk);
    ext = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (en_e) seen = 1'b1;
    end
    s = cnt_e;
    chk(seen, "R13 enable seen", int'(seen), 1);
    @(negedge clk);
    chk(cnt_e == 8'(s + 1), "R13 step after enable", int'(cnt_e), int'(8'(s + 1)));
    chk(!en_e, "R13 single enable", int'(en_e), 0);
    @(negedge clk);
    chk(cnt_e == 8'(s + 1), "R13 hold without enable", int'(cnt_e), int'(8'(s + 1)));
    sel_e = 3'd0;

    // R12: match on non-zero constant, no wrap
    cmp_e = 8'd5; sel_e = 3'd1;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (cma_e) seen = 1'b1;
    end
    chk(seen && cnt_e == 8'd5 && !ovf_e, "R12 match at constant", int'(cnt_e), 5);
    @(negedge clk);
    chk(!cma_e, "R12 match single cycle", int'(cma_e), 0);

    // R11 + R12: wrap and match coincide with constant 0
    cmp_e = 8'd0;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (ovf_e) seen = 1'b1;
    end
    chk(seen && cnt_e == 8'd0, "R11 wrap to zero", int'(cnt_e), 0);
    chk(cma_e, "R12 match with wrap", int'(cma_e), 1);
    @(negedge clk);
    chk(!ovf_e && !cma_e, "R11 wrap single cycle", int'(ovf_e), 0);
    sel_e = 3'd0;

    // R1: reset mid-run clears the count
    sel_o = 3'd1;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cnt_o == 0 && cnt_e == 0, "R1 reset mid-run", int'(cnt_o), 0);
    rst_n = 1'b1; sel_o = 3'd0;
    @(negedge clk);

    done = 1'b1;
    report();
  end

endmodule